// File: doc/BRIEF.md
# Charger Control Register Slave on a Two-Wire Bus

This block is a two-wire serial slave that a host uses to program a small bank of 8-bit charger control registers. The block runs from a system clock that is much faster than the bus. It passes SCL and SDA through a synchronizer, and it finds start, repeated start and stop conditions and the clock edges from the synchronized samples. The slave answers to the fixed 7-bit address 0x6A. It pulls SDA low by raising an output-enable signal, so the pad stays outside the block. A master code of the form 00001xxx, sent as the first byte after a start, is never acknowledged. It raises a high-speed flag that holds until the next stop.

In a write, the first byte is the register pointer and the next byte is the data. The pointer and data pairs repeat until the transaction ends. A read returns the register that the pointer selects. A safety-limit register holds two 4-bit caps. The host may program it only until the first data write to any other address, and that write locks it. Later writes to the voltage and current registers are cut down to those caps. A status input, readable at address 0x00, shows externally supplied flags. A soft-reset bit in the control register restores every register except the limit. A separate input that reports a shorted battery restores the limit and unlocks it.

Top module: `chg_i2c_regs`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal 0x6A (write byte 0xD4, read byte 0xD5) by raising sda_oe_o during the ninth clock. Any other address is not acknowledged, and the rest of that transaction changes no register.
- R2: A first byte after a start whose upper five bits are 00001 is not acknowledged and sets hs_mode_o to 1. A repeated start leaves hs_mode_o at 1, and a stop clears it.
- R3: A write transaction carries the register pointer byte followed by a data byte. Every further pointer and data pair in the same transaction performs another update.
- R4: A register takes the new data only after the SCL falling edge that ends the acknowledge of the data byte. While SCL is high in that acknowledge, the old value is still present.
- R5: Reads return the selected register, MSB first. Address 0x00 returns status_i and ignores writes. Addresses 0x01, 0x02, 0x04 and 0x06 return the control, voltage, current and limit registers. Every other address returns 0xFF.
- R6: A data write to address 0x06 takes effect only while the bank is unlocked. A data write to any other address locks the bank, and later writes to 0x06 are ignored.
- R7: A write to 0x02 stores min(data[7:4], limit[3:0]) in bits 7:4. A write to 0x04 stores min(data[7:4], limit[7:4]) in bits 7:4. Bits 3:0 are stored unchanged in both registers.
- R8: A write to 0x01 with bit 7 set restores control 0x30, voltage 0x0A and current 0x32. The limit register and the lock state are left unchanged, and bit 7 of the control register reads back as 0.
- R9: While vbat_short_i is high, the limit register returns to 0x40 and the bank is unlocked, so 0x06 can be programmed again.
- R10: A stop or a start that arrives before a byte is complete abandons that byte and updates no register. After a start, the slave expects a new address byte.
- R11: After reset, control is 0x30, voltage is 0x0A, current is 0x32, limit is 0x40, hs_mode_o is 0 and sda_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| status_i | input | 8 | Flags read back at address 0x00 |
| vbat_short_i | input | 1 | Battery below short threshold; resets and unlocks the limit |
| sda_oe_o | output | 1 | High to pull SDA low |
| hs_mode_o | output | 1 | High-speed master code seen since the last stop |
| ctrl_o | output | 8 | Control register (0x01) |
| vreg_o | output | 8 | Battery voltage register (0x02) |
| ichg_o | output | 8 | Charge current register (0x04) |
| limit_o | output | 8 | Safety limit register (0x06): [7:4] current cap, [3:0] voltage cap |

## Verification
The properties assume three things about the bus. SCL is clean, with no glitches. Every SCL high and low phase lasts several system clocks. SDA changes only while SCL is low, except for start and stop conditions. The bench drives the bus in quarter-bit steps of four clocks each, so it takes 16 clocks per bit. It changes SDA only in the middle of the low phase and samples the slave's drive in the middle of the high phase. It holds vbat_short_i for whole cycles away from any bus update. The clamp and lock properties therefore see each write in a cycle of its own.

// File: rtl/chg_i2c_pkg.sv
package chg_i2c_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned FW = DW / 2;
  typedef logic [DW-1:0] byte_t;

  localparam byte_t REG_STAT  = 8'h00;
  localparam byte_t REG_CTRL  = 8'h01;
  localparam byte_t REG_VREG  = 8'h02;
  localparam byte_t REG_ICHG  = 8'h04;
  localparam byte_t REG_LIMIT = 8'h06;

  localparam byte_t DEF_CTRL  = 8'h30;
  localparam byte_t DEF_VREG  = 8'h0A;
  localparam byte_t DEF_ICHG  = 8'h32;
  localparam byte_t DEF_LIMIT = 8'h40;
  localparam byte_t RD_MISS   = 8'hFF;

  localparam int unsigned SRST_BIT = DW - 1;
  localparam logic [4:0]  HS_CODE  = 5'b00001;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_REGA, ST_REGA_ACK,
    ST_DATA, ST_DATA_ACK, ST_RD, ST_RD_ACK
  } link_st_e;

  // cap the upper field, keep the lower one
  function automatic byte_t clamp_hi(byte_t v, logic [FW-1:0] cap);
    return {(v[DW-1:FW] > cap) ? cap : v[DW-1:FW], v[FW-1:0]};
  endfunction
endpackage

// File: rtl/chg_i2c_sync.sv
module chg_i2c_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] pipe [STAGES+1];

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe[g] <= '1;
        else         pipe[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe[g] <= '1;
        else         pipe[g] <= pipe[g-1];
    end
  end

  assign q_o    = pipe[STAGES-1];
  assign prev_o = pipe[STAGES];
endmodule

// File: rtl/chg_i2c_link.sv
module chg_i2c_link
  import chg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6A
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  scl_i,
  input  logic  sda_i,
  input  logic  scl_prev_i,
  input  logic  sda_prev_i,
  input  byte_t rd_data_i,
  output logic  sda_oe_o,
  output logic  hs_mode_o,
  output logic  wr_en_o,
  output byte_t ptr_o,
  output byte_t wr_data_o,
  output logic  stop_o
);
  localparam int unsigned CW = $clog2(DW + 1);
  localparam logic [CW-1:0] BYTE_N = CW'(DW);

  link_st_e      state;
  logic [CW-1:0] cnt;
  byte_t         shreg, txreg;
  logic          rw, mack;

  wire start_ev = scl_i & scl_prev_i & sda_prev_i & ~sda_i;
  wire stop_ev  = scl_i & scl_prev_i & ~sda_prev_i & sda_i;
  wire rise     = scl_i & ~scl_prev_i;
  wire fall     = ~scl_i & scl_prev_i;

  assign stop_o    = stop_ev;
  assign wr_data_o = shreg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE; cnt <= '0; shreg <= '0; txreg <= '0; ptr_o <= '0;
      rw <= 1'b0; mack <= 1'b0; sda_oe_o <= 1'b0; hs_mode_o <= 1'b0; wr_en_o <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (stop_ev) begin
        state <= ST_IDLE; sda_oe_o <= 1'b0; hs_mode_o <= 1'b0;
      end else if (start_ev) begin
        state <= ST_ADDR; cnt <= '0; sda_oe_o <= 1'b0;
      end else if (rise) begin
        case (state)
          ST_ADDR, ST_REGA, ST_DATA: begin
            shreg <= {shreg[DW-2:0], sda_i};
            cnt   <= cnt + 1'b1;
          end
          ST_RD:     cnt  <= cnt + 1'b1;
          ST_RD_ACK: mack <= ~sda_i;
          default: ;
        endcase
      end else if (fall) begin
        case (state)
          ST_ADDR: if (cnt == BYTE_N) begin
            if (shreg[DW-1:1] == DEV_ADDR) begin
              sda_oe_o <= 1'b1; rw <= shreg[0]; state <= ST_ADDR_ACK;
            end else begin
              if (shreg[DW-1:3] == HS_CODE) hs_mode_o <= 1'b1;
              state <= ST_IDLE;
            end
          end
          ST_ADDR_ACK: begin
            cnt <= '0;
            if (rw) begin
              txreg <= rd_data_i; sda_oe_o <= ~rd_data_i[DW-1]; state <= ST_RD;
            end else begin
              sda_oe_o <= 1'b0; state <= ST_REGA;
            end
          end
          ST_REGA: if (cnt == BYTE_N) begin
            sda_oe_o <= 1'b1; ptr_o <= shreg; state <= ST_REGA_ACK;
          end
          ST_REGA_ACK: begin
            sda_oe_o <= 1'b0; cnt <= '0; state <= ST_DATA;
          end
          ST_DATA: if (cnt == BYTE_N) begin
            sda_oe_o <= 1'b1; state <= ST_DATA_ACK;
          end
          ST_DATA_ACK: begin
            sda_oe_o <= 1'b0; wr_en_o <= 1'b1; cnt <= '0; state <= ST_REGA;
          end
          ST_RD: if (cnt == BYTE_N) begin
            sda_oe_o <= 1'b0; state <= ST_RD_ACK;
          end else begin
            txreg <= {txreg[DW-2:0], 1'b0}; sda_oe_o <= ~txreg[DW-2];
          end
          ST_RD_ACK: if (mack) begin
            txreg <= rd_data_i; sda_oe_o <= ~rd_data_i[DW-1]; cnt <= '0; state <= ST_RD;
          end else begin
            state <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/chg_i2c_bank.sv
module chg_i2c_bank
  import chg_i2c_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  byte_t ptr_i,
  input  byte_t wr_data_i,
  input  byte_t status_i,
  input  logic  vbat_short_i,
  output byte_t rd_data_o,
  output byte_t ctrl_o,
  output byte_t vreg_o,
  output byte_t ichg_o,
  output byte_t limit_o,
  output logic  locked_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= DEF_CTRL; vreg_o <= DEF_VREG; ichg_o <= DEF_ICHG;
      limit_o <= DEF_LIMIT; locked_o <= 1'b0;
    end else begin
      if (vbat_short_i) begin
        limit_o <= DEF_LIMIT; locked_o <= 1'b0;
      end
      if (wr_en_i) begin
        if (ptr_i == REG_LIMIT) begin
          if (!locked_o && !vbat_short_i) limit_o <= wr_data_i;
        end else begin
          if (!vbat_short_i) locked_o <= 1'b1;
          case (ptr_i)
            REG_CTRL:
              if (wr_data_i[SRST_BIT]) begin
                ctrl_o <= DEF_CTRL; vreg_o <= DEF_VREG; ichg_o <= DEF_ICHG;
              end else begin
                ctrl_o <= wr_data_i;
              end
            REG_VREG: vreg_o <= clamp_hi(wr_data_i, limit_o[FW-1:0]);
            REG_ICHG: ichg_o <= clamp_hi(wr_data_i, limit_o[DW-1:FW]);
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (ptr_i)
      REG_STAT:  rd_data_o = status_i;
      REG_CTRL:  rd_data_o = ctrl_o;
      REG_VREG:  rd_data_o = vreg_o;
      REG_ICHG:  rd_data_o = ichg_o;
      REG_LIMIT: rd_data_o = limit_o;
      default:   rd_data_o = RD_MISS;
    endcase
  end
endmodule

// File: rtl/chg_i2c_regs.sv
module chg_i2c_regs
  import chg_i2c_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h6A,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [7:0] status_i,
  input  logic       vbat_short_i,
  output logic       sda_oe_o,
  output logic       hs_mode_o,
  output logic [7:0] ctrl_o,
  output logic [7:0] vreg_o,
  output logic [7:0] ichg_o,
  output logic [7:0] limit_o
);
  logic [1:0] bus_q, bus_prev;
  logic       wr_en, stop_evt, locked;
  byte_t      ptr, wr_data, rd_data;

  chg_i2c_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i({scl_i, sda_i}), .q_o(bus_q), .prev_o(bus_prev)
  );

  chg_i2c_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk_i, .rst_ni,
    .scl_i(bus_q[1]), .sda_i(bus_q[0]),
    .scl_prev_i(bus_prev[1]), .sda_prev_i(bus_prev[0]),
    .rd_data_i(rd_data), .sda_oe_o, .hs_mode_o,
    .wr_en_o(wr_en), .ptr_o(ptr), .wr_data_o(wr_data), .stop_o(stop_evt)
  );

  chg_i2c_bank u_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .ptr_i(ptr), .wr_data_i(wr_data),
    .status_i, .vbat_short_i, .rd_data_o(rd_data),
    .ctrl_o, .vreg_o, .ichg_o, .limit_o, .locked_o(locked)
  );
endmodule

// File: rtl/chg_i2c_chk.sv
module chg_i2c_chk
  import chg_i2c_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  stop_i,
  input logic  hs_i,
  input logic  sda_oe_i,
  input logic  wr_en_i,
  input byte_t ptr_i,
  input byte_t wr_data_i,
  input logic  vbat_short_i,
  input logic  locked_i,
  input byte_t vreg_i,
  input byte_t ichg_i,
  input byte_t limit_i
);
  // R2
  hs_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !hs_i);

  // R1
  oe_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i);

  // R6
  limit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i && !vbat_short_i |=> $stable(limit_i));

  // R7
  vreg_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && ptr_i == REG_VREG |=> vreg_i[DW-1:FW] <= $past(limit_i[FW-1:0]));

  // R7
  ichg_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && ptr_i == REG_ICHG |=> ichg_i[DW-1:FW] <= $past(limit_i[DW-1:FW]));

  // R9
  limit_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vbat_short_i |=> limit_i == DEF_LIMIT && !locked_i);

  // R8
  soft_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && ptr_i == REG_CTRL && wr_data_i[SRST_BIT] && !vbat_short_i
    |=> vreg_i == DEF_VREG && ichg_i == DEF_ICHG && $stable(limit_i));
endmodule

bind chg_i2c_regs chg_i2c_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(stop_evt), .hs_i(hs_mode_o),
  .sda_oe_i(sda_oe_o), .wr_en_i(wr_en), .ptr_i(ptr), .wr_data_i(wr_data),
  .vbat_short_i(vbat_short_i), .locked_i(locked), .vreg_i(vreg_o),
  .ichg_i(ichg_o), .limit_i(limit_o)
);

// File: tb/chg_i2c_regs_bench.sv
`timescale 1ns/1ps
module chg_i2c_regs_bench;
  localparam real Q = 20.0;
  localparam logic [7:0] WADDR = 8'hD4;
  localparam logic [7:0] RADDR = 8'hD5;
  localparam logic [7:0] STAT  = 8'hC3;
  // {reg, write data, expected read}; limit is 0x7A while walked
  localparam logic [23:0] VEC [8] = '{
    24'h02_55_55, 24'h02_F3_A3, 24'h04_61_61, 24'h04_9C_7C,
    24'h01_15_15, 24'h03_12_FF, 24'h06_11_7A, 24'h00_00_C3
  };

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, vshort = 1'b0;
  logic sda_oe, hs;
  logic [7:0] ctrl, vreg, ichg, limit;
  wire sda_bus = m_sda & ~sda_oe;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chg_i2c_regs u_chg_i2c_regs (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .status_i(STAT), .vbat_short_i(vshort), .sda_oe_o(sda_oe), .hs_mode_o(hs),
    .ctrl_o(ctrl), .vreg_o(vreg), .ichg_o(ichg), .limit_o(limit)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic rd);
    #Q m_sda = b; #Q m_scl = 1'b1; #Q rd = sda_bus; #Q m_scl = 1'b0;
  endtask

  task automatic i2c_start();
    #Q m_sda = 1'b1; #Q m_scl = 1'b1; #Q m_sda = 1'b0; #Q m_scl = 1'b0;
  endtask

  task automatic i2c_stop();
    #Q m_sda = 1'b0; #Q m_scl = 1'b1; #Q m_sda = 1'b1; #Q;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic d;
    for (int i = 7; i >= 0; i--) bit_io(b[i], d);
    bit_io(1'b1, d);
    ack = ~d;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic d;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, d); b[i] = d; end
    bit_io(~mack, d);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] v);
    logic k;
    i2c_start(); send_byte(WADDR, k); send_byte(a, k); send_byte(v, k); i2c_stop();
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
    logic k;
    i2c_start(); send_byte(WADDR, k); send_byte(a, k);
    i2c_start(); send_byte(RADDR, k); recv_byte(1'b0, v); i2c_stop();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic k;
    logic d;
    logic [7:0] v;
    #52 rst_n = 1'b1;
    #8;
    // R11 reset state
    chk("R11 ctrl", ctrl, 8'h30);  chk("R11 vreg", vreg, 8'h0A);
    chk("R11 ichg", ichg, 8'h32);  chk("R11 limit", limit, 8'h40);
    chk("R11 hs/oe", {6'd0, hs, sda_oe}, 8'h00);

    // R1 address match and mismatch
    i2c_start(); send_byte(WADDR, k); chk("R1 own ack", {7'd0, k}, 8'h01); i2c_stop();
    i2c_start(); send_byte(8'hD6, k); chk("R1 other nack", {7'd0, k}, 8'h00);
    send_byte(8'h02, k); send_byte(8'h11, k); i2c_stop();
    chk("R1 other no write", vreg, 8'h0A);

    // R6 limit programmable before any other write
    wr_reg(8'h06, 8'h7A);
    rd_reg(8'h06, v); chk("R6 limit write", v, 8'h7A);

    // R5 R6 R7 vector walk
    for (int i = 0; i < 8; i++) begin
      wr_reg(VEC[i][23:16], VEC[i][15:8]);
      rd_reg(VEC[i][23:16], v);
      chk($sformatf("R5/R6/R7 vec%0d", i), v, VEC[i][7:0]);
    end
    rd_reg(8'h05, v); chk("R5 unimplemented", v, 8'hFF);
    chk("R7 ichg port", ichg, 8'h7C);

    // R3 two pairs in one transaction
    i2c_start(); send_byte(WADDR, k); send_byte(8'h02, k); send_byte(8'h21, k);
    send_byte(8'h04, k); send_byte(8'h43, k); i2c_stop();
    chk("R3 first pair", vreg, 8'h21); chk("R3 second pair", ichg, 8'h43);

    // R4 update at fall ending the data acknowledge
    i2c_start(); send_byte(WADDR, k); send_byte(8'h02, k);
    for (int i = 7; i >= 0; i--) bit_io(i == 5 || i == 4 || i == 2 || i == 1, d);
    #Q m_sda = 1'b1; #Q m_scl = 1'b1; #Q chk("R4 old during ack", vreg, 8'h21);
    #Q m_scl = 1'b0; #(2*Q) chk("R4 new after fall", vreg, 8'h36);
    i2c_stop();

    // R10 stop mid-byte
    i2c_start(); send_byte(WADDR, k); send_byte(8'h02, k);
    bit_io(1'b1, d); bit_io(1'b0, d); bit_io(1'b0, d); bit_io(1'b1, d);
    i2c_stop();
    chk("R10 stop abort", vreg, 8'h36);
    // R10 start mid-byte
    i2c_start(); send_byte(WADDR, k); send_byte(8'h02, k);
    bit_io(1'b0, d); bit_io(1'b1, d); bit_io(1'b1, d);
    i2c_start(); send_byte(WADDR, k); send_byte(8'h04, k); send_byte(8'h25, k); i2c_stop();
    chk("R10 start abort vreg", vreg, 8'h36);
    chk("R10 restart write", ichg, 8'h25);

    // R2 high-speed master code
    i2c_start(); send_byte(8'h09, k);
    chk("R2 code nack", {7'd0, k}, 8'h00);
    chk("R2 flag set", {7'd0, hs}, 8'h01);
    i2c_start(); send_byte(WADDR, k); send_byte(8'h01, k); send_byte(8'h16, k);
    chk("R2 kept on restart", {7'd0, hs}, 8'h01);
    i2c_stop();
    chk("R2 cleared on stop", {7'd0, hs}, 8'h00);
    chk("R2 write in hs", ctrl, 8'h16);

    // R8 soft reset
    wr_reg(8'h01, 8'h80);
    chk("R8 ctrl", ctrl, 8'h30); chk("R8 vreg", vreg, 8'h0A);
    chk("R8 ichg", ichg, 8'h32); chk("R8 limit kept", limit, 8'h7A);
    wr_reg(8'h06, 8'h22);
    chk("R8 lock kept", limit, 8'h7A);

    // R9 short input restores and unlocks limit
    @(negedge clk) vshort = 1'b1;
    repeat (3) @(negedge clk);
    vshort = 1'b0;
    chk("R9 limit default", limit, 8'h40);
    wr_reg(8'h06, 8'h5B);
    chk("R9 unlocked write", limit, 8'h5B);
    wr_reg(8'h02, 8'hF0);
    chk("R9 new cap applied", vreg, 8'hB0);
    wr_reg(8'h06, 8'h11);
    chk("R9 relocked", limit, 8'h5B);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule